// File: doc/BRIEF.md
# Parking Bus Arbiter

This block hands ownership of a shared bus to one of up to `NUM_MASTERS` masters. Each master raises its request line. The arbiter answers with a one-hot grant vector. The granted master marks the start of its transaction with a one-cycle `start` pulse. That pulse opens the address tenure. An `addr_ack` pulse closes the address tenure, and a `data_done` pulse closes one data phase. All grant decisions are registered, so a new grant appears one clock after the inputs that caused it.

When nobody requests, the arbiter can keep the grant parked on one master, so that master can begin without waiting for arbitration. A configuration register selects the parking policy and the programmed parked master, and it holds a pipelining-disable flag. The register loads from the `cfg_*` pins when `cfg_wr` is high and takes effect from the following cycle. With pipelining disabled, the arbiter waits for every outstanding data phase to finish before it grants again. With pipelining enabled, it may grant again as soon as the address tenure closes, provided fewer than `MAX_OUT` data phases are pending.

Top module: `arb_park_top`

## Requirements
- R1: Reset drives no grant and sets the parking mode to none, the programmed master to 0, pipelining-disable to 1 and the recorded last owner to master 0.
- R2: With mode code 00 or 01, and with no request and a free bus, no grant is driven on the next cycle.
- R3: With mode code 10, an idle free bus parks the grant on the master whose transaction started most recently.
- R4: With mode code 11, an idle free bus parks the grant on the master given by the 3-bit programmed-master field.
- R5: When the bus is free and requests are present, the next grant goes to the first requesting master found by searching upward, wrapping around, from the master after the last owner. Grant bit i belongs to master i.
- R6: A master holding a grant it has not yet used keeps that grant without a gap once it requests, even when others also request. When the parked master is not requesting, a request from another master moves the grant one cycle later.
- R7: At most one grant bit is high in any cycle.
- R8: The grant does not change from an accepted `start` until the cycle after its `addr_ack`.
- R9: With pipelining-disable at 1, the grant holds while any data phase is pending. With it at 0, a new grant may be issued while data phases are pending, as long as fewer than `MAX_OUT` are outstanding.
- R10: `start` is ignored when no grant is out, `addr_ack` is ignored outside an address tenure, and `data_done` is ignored with no data phase pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_MASTERS | Per-master bus request |
| start | input | 1 | Granted master begins a transaction (address tenure opens) |
| addr_ack | input | 1 | Address tenure closes; a data phase becomes pending |
| data_done | input | 1 | One pending data phase completes |
| cfg_wr | input | 1 | Loads the configuration register |
| cfg_park_mode | input | 2 | Parking mode: 00 none, 01 reserved (as none), 10 last owner, 11 programmed |
| cfg_park_sel | input | IDW | Programmed parked master |
| cfg_pipe_dis | input | 1 | 1 = no grant until all data phases finish |
| gnt | output | NUM_MASTERS | One-hot grant, or all zero |

## Verification
The hardest state to reach is the round-robin search starting from each possible last owner. The last owner can only be set by completing a real transaction from that master, so the stimulus runs a full start/acknowledge/data sequence for every master before each request pattern. It then sweeps all 255 non-empty request patterns from each of those starting points. The pipelined case with `MAX_OUT` data phases outstanding needs two back-to-back address tenures under different owners. A directed sequence stacks them and then checks that the grant freezes until one phase drains.

// File: rtl/arb_park_pkg.sv
package arb_park_pkg;

  typedef enum logic [1:0] {
    PARK_NONE = 2'b00,
    PARK_RSVD = 2'b01,
    PARK_LAST = 2'b10,
    PARK_PROG = 2'b11
  } park_mode_e;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] pick
);

  // search upward from last+1, wrapping, first hit wins
  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(last) + k;
      if (idx >= N) idx = idx - N;
      if (!any && req[IW'(idx)]) begin
        any  = 1'b1;
        pick = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/arb_park_target.sv
module arb_park_target
  import arb_park_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  park_mode_e    mode,
  input  logic [IW-1:0] sel,
  input  logic [IW-1:0] last,
  output logic          park_v,
  output logic [IW-1:0] park_id
);

  always_comb begin
    park_v  = 1'b0;
    park_id = '0;
    unique case (mode)
      PARK_LAST: begin
        park_v  = 1'b1;
        park_id = last;
      end
      PARK_PROG: begin
        park_v  = (int'(sel) < N);
        park_id = sel;
      end
      default: begin
        park_v  = 1'b0;
        park_id = '0;
      end
    endcase
  end

endmodule

// File: rtl/arb_tenure.sv
module arb_tenure #(
  parameter int MAX_OUT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_acc,
  input  logic addr_ack,
  input  logic data_done,
  input  logic pipe_dis,
  output logic addr_busy,
  output logic data_idle,
  output logic free
);

  localparam int CW = $clog2(MAX_OUT + 1);

  logic          busy_q;
  logic [CW-1:0] pend_q;
  logic          ack_ok;
  logic          done_ok;

  assign ack_ok  = addr_ack && busy_q;
  assign done_ok = data_done && (pend_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
    end else begin
      if (start_acc)   busy_q <= 1'b1;
      else if (ack_ok) busy_q <= 1'b0;
      if (ack_ok && !done_ok)      pend_q <= pend_q + 1'b1;
      else if (!ack_ok && done_ok) pend_q <= pend_q - 1'b1;
    end
  end

  assign addr_busy = busy_q;
  assign data_idle = (pend_q == '0);
  assign free = !busy_q && (pipe_dis ? (pend_q == '0) : (pend_q < CW'(MAX_OUT)));

endmodule

// File: rtl/arb_park_top.sv
module arb_park_top
  import arb_park_pkg::*;
#(
  parameter  int NUM_MASTERS = 8,
  parameter  int MAX_OUT     = 2,
  localparam int IDW         = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   start,
  input  logic                   addr_ack,
  input  logic                   data_done,
  input  logic                   cfg_wr,
  input  logic [1:0]             cfg_park_mode,
  input  logic [IDW-1:0]         cfg_park_sel,
  input  logic                   cfg_pipe_dis,
  output logic [NUM_MASTERS-1:0] gnt
);

  park_mode_e     mode_q;
  logic [IDW-1:0] sel_q;
  logic           pipe_dis_q;

  logic           gnt_v_q;
  logic [IDW-1:0] gnt_id_q;
  logic [IDW-1:0] last_q;
  logic           served_q;

  logic           addr_busy, data_idle, free, start_acc;
  logic           rr_any, park_v;
  logic [IDW-1:0] rr_pick, park_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= PARK_NONE;
      sel_q      <= '0;
      pipe_dis_q <= 1'b1;
    end else if (cfg_wr) begin
      mode_q     <= park_mode_e'(cfg_park_mode);
      sel_q      <= cfg_park_sel;
      pipe_dis_q <= cfg_pipe_dis;
    end
  end

  assign start_acc = start && gnt_v_q && free;

  arb_tenure #(.MAX_OUT(MAX_OUT)) u_ten (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .addr_ack  (addr_ack),
    .data_done (data_done),
    .pipe_dis  (pipe_dis_q),
    .addr_busy (addr_busy),
    .data_idle (data_idle),
    .free      (free)
  );

  arb_rr_pick #(.N(NUM_MASTERS), .IW(IDW)) u_rr (
    .req  (req),
    .last (last_q),
    .any  (rr_any),
    .pick (rr_pick)
  );

  arb_park_target #(.N(NUM_MASTERS), .IW(IDW)) u_park (
    .mode    (mode_q),
    .sel     (sel_q),
    .last    (last_q),
    .park_v  (park_v),
    .park_id (park_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_v_q  <= 1'b0;
      gnt_id_q <= '0;
      last_q   <= '0;
      served_q <= 1'b0;
    end else if (start_acc) begin
      last_q   <= gnt_id_q;
      served_q <= 1'b1;
    end else if (free) begin
      if (gnt_v_q && req[gnt_id_q] && !served_q) begin
        gnt_v_q <= 1'b1;            // unused grant, holder now asks: keep it
      end else if (rr_any) begin
        gnt_v_q  <= 1'b1;
        gnt_id_q <= rr_pick;
        served_q <= 1'b0;
      end else begin
        gnt_v_q  <= park_v;
        gnt_id_q <= park_id;
        served_q <= 1'b0;
      end
    end
  end

  always_comb begin
    gnt = '0;
    if (gnt_v_q) gnt[gnt_id_q] = 1'b1;
  end

endmodule

// File: rtl/arb_park_chk.sv
module arb_park_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic [N-1:0]  gnt,
  input logic          start,
  input logic          addr_busy,
  input logic          data_idle,
  input logic          free,
  input logic          served,
  input logic [1:0]    mode,
  input logic [IW-1:0] sel,
  input logic          pipe_dis
);

  a_r7_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r8_hold_in_tenure: assert property (@(posedge clk) disable iff (!rst_n)
    addr_busy |=> $stable(gnt));

  a_r9_hold_data_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_dis && !data_idle) |=> $stable(gnt));

  a_r2_no_park: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && (req == '0) && free && !(start && |gnt)) |=> (gnt == '0));

  a_r4_prog_park: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b11) && (req == '0) && free && !(start && |gnt))
      |=> (gnt == (N'(1) << $past(sel))));

  a_r6_keep_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !served && |(gnt & req)) |=> $stable(gnt));

endmodule

bind arb_park_top arb_park_chk #(.N(NUM_MASTERS), .IW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .gnt       (gnt),
  .start     (start),
  .addr_busy (addr_busy),
  .data_idle (data_idle),
  .free      (free),
  .served    (served_q),
  .mode      (mode_q),
  .sel       (sel_q),
  .pipe_dis  (pipe_dis_q)
);

// File: tb/sim_arb_park_top.sv
module sim_arb_park_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       start = 1'b0, addr_ack = 1'b0, data_done = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_park_mode = '0;
  logic [2:0] cfg_park_sel = '0;
  logic       cfg_pipe_dis = 1'b1;
  logic [7:0] gnt;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arb_park_top #(.NUM_MASTERS(8), .MAX_OUT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .start(start), .addr_ack(addr_ack),
    .data_done(data_done), .cfg_wr(cfg_wr), .cfg_park_mode(cfg_park_mode),
    .cfg_park_sel(cfg_park_sel), .cfg_pipe_dis(cfg_pipe_dis), .gnt(gnt)
  );

  task automatic chk(input string rq, input logic [7:0] exp);
    vectors++;
    if (gnt !== exp) begin
      fails++;
      $display("FAIL %s: gnt=%b expected %b", rq, gnt, exp);
    end
  endtask

  // drive for one cycle; outputs sampled at the following falling edge
  task automatic tick(input logic [7:0] r, input logic s, input logic a, input logic d);
    req = r; start = s; addr_ack = a; data_done = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr = 1'b0;
    tick(8'h00, 0, 0, 0);
    tick(8'h00, 0, 0, 0);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input logic [1:0] m, input logic [2:0] s, input logic p);
    cfg_park_mode = m; cfg_park_sel = s; cfg_pipe_dis = p; cfg_wr = 1'b1;
    tick(8'h00, 0, 0, 0);
    cfg_wr = 1'b0;
    tick(8'h00, 0, 0, 0);
  endtask

  // full transaction by master l, leaving l as last owner
  task automatic run_tx(input int l);
    tick(8'(1 << l), 0, 0, 0);
    chk("R5 lone requester", 8'(1 << l));
    tick(8'(1 << l), 1, 0, 0);
    tick(8'(1 << l), 0, 1, 0);
    tick(8'h00, 0, 0, 1);
    tick(8'h00, 0, 0, 0);
  endtask

  function automatic logic [7:0] exp_rr(input int l, input logic [7:0] p);
    for (int k = 1; k <= 8; k++) begin
      if (p[(l + k) % 8]) return 8'(1 << ((l + k) % 8));
    end
    return 8'h00;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 reset grant", 8'h00);
    tick(8'h00, 0, 0, 0);
    chk("R2 idle mode 00", 8'h00);

    // R9 with reset-default pipelining-disable, R1 default last owner 0
    tick(8'b0000_0110, 0, 0, 0);
    chk("R5 search after master 0", 8'b0000_0010);
    tick(8'b0000_0110, 1, 0, 0);
    tick(8'b0000_0110, 0, 1, 0);
    chk("R8 hold at ack", 8'b0000_0010);
    tick(8'b0000_0110, 0, 0, 0);
    chk("R9 hold while data pending", 8'b0000_0010);
    tick(8'b0000_0110, 0, 0, 1);
    chk("R9 hold on done cycle", 8'b0000_0010);
    tick(8'b0000_0110, 0, 0, 0);
    chk("R9 regrant after data", 8'b0000_0100);
    tick(8'h00, 0, 0, 0);
    chk("R2 drop to none", 8'h00);

    // R1 last owner resets to master 0
    do_reset();
    cfg(2'b10, 3'd0, 1'b1);
    chk("R1 R3 park on master 0 after reset", 8'b0000_0001);

    // R2 reserved mode behaves as none
    cfg(2'b01, 3'd5, 1'b1);
    chk("R2 mode 01 idle", 8'h00);
    run_tx(3);
    chk("R2 mode 01 after tx", 8'h00);

    // R3 sweep over last owner
    cfg(2'b10, 3'd0, 1'b1);
    for (int l = 0; l < 8; l++) begin
      run_tx(l);
      chk("R3 park on last owner", 8'(1 << l));
    end

    // R4 sweep over programmed master
    for (int s = 0; s < 8; s++) begin
      cfg(2'b11, 3'(s), 1'b1);
      chk("R4 park on programmed", 8'(1 << s));
    end

    // R6 keep / switch
    cfg(2'b11, 3'd3, 1'b1);
    tick(8'b0000_1000, 0, 0, 0);
    chk("R6 parked keeps on request", 8'b0000_1000);
    tick(8'b0100_1000, 0, 0, 0);
    chk("R6 parked keeps vs competitor", 8'b0000_1000);
    tick(8'h00, 0, 0, 0);
    chk("R4 back to park", 8'b0000_1000);
    tick(8'b0010_0000, 0, 0, 0);
    chk("R6 other requester switches", 8'b0010_0000);
    tick(8'h00, 0, 0, 0);

    // R8 hold through address tenure
    cfg(2'b00, 3'd0, 1'b1);
    tick(8'b0001_0000, 0, 0, 0);
    chk("R5 grant 4", 8'b0001_0000);
    tick(8'b0001_0000, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      tick(8'b0100_0000, 0, 0, 0);
      chk("R8 hold in tenure", 8'b0001_0000);
    end
    tick(8'b0100_0000, 0, 1, 0);
    chk("R8 hold at ack", 8'b0001_0000);
    tick(8'b0100_0000, 0, 0, 1);
    chk("R9 hold on done", 8'b0001_0000);
    tick(8'b0100_0000, 0, 0, 0);
    chk("R8 switch after tenure", 8'b0100_0000);
    tick(8'h00, 0, 0, 0);

    // R9 pipelined overlap up to MAX_OUT pending
    cfg(2'b00, 3'd0, 1'b0);
    tick(8'b0000_0010, 0, 0, 0);
    chk("R5 grant 1", 8'b0000_0010);
    tick(8'b0000_0100, 1, 0, 0);
    tick(8'b0000_0100, 0, 1, 0);
    chk("R8 hold at ack", 8'b0000_0010);
    tick(8'b0000_0100, 0, 0, 0);
    chk("R9 overlap grant", 8'b0000_0100);
    tick(8'b0001_0000, 1, 0, 0);
    tick(8'b0001_0000, 0, 1, 0);
    chk("R8 hold at second ack", 8'b0000_0100);
    tick(8'b0001_0000, 0, 0, 0);
    chk("R9 hold at MAX_OUT pending", 8'b0000_0100);
    tick(8'b0001_0000, 0, 0, 1);
    chk("R9 hold on done", 8'b0000_0100);
    tick(8'b0001_0000, 0, 0, 0);
    chk("R9 regrant below limit", 8'b0001_0000);
    tick(8'h00, 0, 0, 1);
    chk("R2 idle after drain", 8'h00);
    cfg(2'b00, 3'd0, 1'b1);

    // R10 stray control pulses
    tick(8'h00, 1, 0, 0);
    tick(8'b0000_0100, 0, 0, 0);
    chk("R10 start without grant ignored", 8'b0000_0100);
    tick(8'h00, 0, 1, 0);
    chk("R10 drop grant", 8'h00);
    tick(8'h00, 0, 0, 1);
    tick(8'b0010_0000, 0, 0, 0);
    chk("R10 stray ack and done ignored", 8'b0010_0000);
    tick(8'h00, 0, 0, 0);

    // R5 / R7 full sweep: every last owner, every request pattern
    for (int l = 0; l < 8; l++) begin
      for (int p = 1; p < 256; p++) begin
        run_tx(l);
        tick(8'(p), 0, 0, 0);
        chk("R5 round-robin", exp_rr(l, 8'(p)));
        vectors++;
        if ($countones(gnt) > 1) begin
          fails++;
          $display("FAIL R7: gnt=%b expected at most one bit", gnt);
        end
        tick(8'h00, 0, 0, 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule